// File: doc/BRIEF.md
# Packed Int8 Quantized Dot-Product Pipeline

The block computes one scaled dot product per operand group. A group holds operand bytes for a chain of `STAGES` processing stages, 12 by default. Each stage takes two signed 8-bit operand pairs and multiplies each pair in its own lane. It sign-extends both 16-bit products to 24 bits and adds them to the running partial sum that it receives from the stage before it. Every stage is registered, so the operands for stage k are skewed by k cycles and meet the partial sum as it passes. The final 24-bit integer is converted exactly to a single-precision float. That float is multiplied by a per-group 32-bit float scale, and the product appears on the output together with a one-cycle strobe.

The block is fully pipelined and accepts a new group on every cycle while `in_ready` is high. A two-state control machine decides readiness. The `HOLD` state is entered whenever reset is high, and `in_ready` is low in it. The `FLOW` state is reached from `HOLD` by the transition `RELEASE`, which fires on the first clock edge with reset low, and `in_ready` is high in it. `FLOW` returns to `HOLD` only through reset.

Top module: `qdot_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge that samples it high, `in_ready` and `out_valid` are low. On the clock edge after the first edge that samples `rst` low, `in_ready` is high and it stays high.
- R2: Stage k takes its operands from `in_ops[32k+31:32k]`, laid out as bits [7:0] lane-0 a, [15:8] lane-0 b, [23:16] lane-1 a and [31:24] lane-1 b, all two's complement. The integer result is the sum over all stages and both lanes of the signed products.
- R3: The result of a group accepted on clock edge E appears with `out_valid` high after edge E + `STAGES` + 1, which is 13 edges at the default.
- R4: The integer sum converts to float without loss. The full-scale sum 24 × (−128 × −128) with a scale of 1.0 gives 0x48C00000. A zero sum gives +0.0 (0x00000000) with a positive scale and −0.0 (0x80000000) with a negative scale.
- R5: The float multiply rounds to nearest, with ties going to the even mantissa. 3 × 0x3F800001 gives 0x40400002, and 5 × 0x3F800002 gives 0x40A00002.
- R6: No result is subnormal. The smallest normal scale 0x00800000 times ±1 gives 0x00800000 or 0x80800000.
- R7: A product above the largest finite float gives a signed infinity. 0x7F7FFFFF × 2 gives 0x7F800000, 0x7F7FFFFF × −3 gives 0xFF800000, and 0x7F7FFFFF × 1 gives 0x7F7FFFFF.
- R8: A NaN scale (exponent field 0xFF, fraction field nonzero, either sign) gives the quiet NaN 0x7FC00000.
- R9: An infinite scale times a zero sum gives 0x7FC00000. An infinite scale times a nonzero sum gives an infinity whose sign is the XOR of the two signs.
- R10: A subnormal scale (exponent field 0, fraction field nonzero) counts as zero, so the result is a zero whose sign is the XOR of the two signs.
- R11: A cycle with `in_valid` low accepts nothing and produces no `out_valid` pulse, whatever is present on `in_ops` and `in_scale`.
- R12: Groups presented on consecutive cycles give results on consecutive cycles, in the order they were accepted, with exactly one `out_valid` pulse per group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand group and scale are presented |
| in_ready | output | 1 | Block accepts a group on this edge |
| in_ops | input | STAGES*32 | Packed signed byte operands, 32 bits per stage |
| in_scale | input | 32 | Single-precision scale for the group |
| out_valid | output | 1 | One-cycle strobe for a finished group |
| out_result | output | 32 | Single-precision scaled dot product |

## Verification
The assertions assume that `in_valid` and `in_scale` carry known two-state values on every sampled edge. They also assume that `in_valid` is low or ignored while reset is high, because the history registers that forecast output strobes and NaN or subnormal-scale results start from the acceptance edge. The stimulus changes inputs only at falling edges and always with defined values. This includes the junk data driven during bubble cycles. The stimulus holds `in_valid` low until `in_ready` has risen. A near-exhaustive sweep of every signed byte against the extreme multiplier values, across all stages and both lanes, exercises the product and sign-extension path. Directed scales then cover rounding ties, overflow, NaN, infinity and subnormal inputs.

// File: rtl/qdot_pkg.sv
package qdot_pkg;
    localparam int ACC_W      = 24;
    localparam int LANE_OPS_W = 32;
    localparam int FP_W       = 32;

    typedef struct packed {
        logic       sgn;
        logic [7:0] expo;
        logic [22:0] frac;
    } fp32_t;

    localparam logic [FP_W-1:0] FP_QNAN = 32'h7FC00000;

    typedef enum logic {
        ST_HOLD,
        ST_FLOW
    } ctl_state_t;
endpackage

// File: rtl/qdot_delay.sv
module qdot_delay #(
    parameter int W = 32,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [D];

    always_ff @(posedge clk) begin
        pipe[0] <= din;
        for (int i = 1; i < D; i++) begin
            pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[D-1];
endmodule

// File: rtl/qdot_stage.sv
module qdot_stage
    import qdot_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  v_in,
    input  logic [ACC_W-1:0]      sum_in,
    input  logic [LANE_OPS_W-1:0] ops,
    output logic                  v_out,
    output logic [ACC_W-1:0]      sum_out
);
    logic signed [7:0]  a0, b0, a1, b1;
    logic signed [15:0] p0, p1;
    logic [ACC_W-1:0]   x0, x1;

    assign a0 = ops[7:0];
    assign b0 = ops[15:8];
    assign a1 = ops[23:16];
    assign b1 = ops[31:24];

    // two-lane signed multiply, each product widened with its sign
    assign p0 = a0 * b0;
    assign p1 = a1 * b1;
    assign x0 = {{(ACC_W-16){p0[15]}}, p0};
    assign x1 = {{(ACC_W-16){p1[15]}}, p1};

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
        end else begin
            v_out <= v_in;
        end
        sum_out <= sum_in + x0 + x1;
    end
endmodule

// File: rtl/qdot_i2f.sv
module qdot_i2f
    import qdot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             v_in,
    input  logic [ACC_W-1:0] sum_in,
    input  logic [FP_W-1:0]  scale_in,
    output logic             v_out,
    output fp32_t            fval,
    output fp32_t            scale_out
);
    localparam int MSB_W = $clog2(ACC_W);

    logic             neg;
    logic [ACC_W-1:0] mag;
    logic [MSB_W-1:0] msb;
    logic [MSB_W-1:0] sh;
    logic [22:0]      fr;
    fp32_t            conv;

    assign neg = sum_in[ACC_W-1];
    assign mag = neg ? (~sum_in + 1'b1) : sum_in;

    always_comb begin
        msb = '0;
        for (int i = 0; i < ACC_W; i++) begin
            if (mag[i]) msb = MSB_W'(i);
        end
    end

    assign sh = MSB_W'(ACC_W - 1) - msb;
    assign fr = 23'(mag << sh);

    always_comb begin
        if (mag == '0) begin
            conv = '0;
        end else begin
            conv.sgn  = neg;
            conv.expo = 8'(127 + int'(msb));
            conv.frac = fr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
        end else begin
            v_out <= v_in;
        end
        fval      <= conv;
        scale_out <= scale_in;
    end
endmodule

// File: rtl/qdot_fmul.sv
module qdot_fmul
    import qdot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            v_in,
    input  fp32_t           a,
    input  fp32_t           b,
    output logic            v_out,
    output logic [FP_W-1:0] res
);
    logic               a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, sgn;
    logic [47:0]        prod;
    logic signed [10:0] e0, e1, e2;
    logic [23:0]        mant;
    logic               g, st, up;
    logic [24:0]        mr;
    logic [22:0]        m;
    logic [FP_W-1:0]    nxt;

    assign a_zero = (a.expo == 8'h00);
    assign b_zero = (b.expo == 8'h00);
    assign a_inf  = (a.expo == 8'hFF) && (a.frac == '0);
    assign b_inf  = (b.expo == 8'hFF) && (b.frac == '0);
    assign a_nan  = (a.expo == 8'hFF) && (a.frac != '0);
    assign b_nan  = (b.expo == 8'hFF) && (b.frac != '0);
    assign sgn    = a.sgn ^ b.sgn;

    assign prod = {1'b1, a.frac} * {1'b1, b.frac};
    assign e0   = $signed({3'b000, a.expo}) + $signed({3'b000, b.expo}) - 11'sd127;

    always_comb begin
        if (prod[47]) begin
            mant = prod[47:24];
            g    = prod[23];
            st   = |prod[22:0];
            e1   = e0 + 11'sd1;
        end else begin
            mant = prod[46:23];
            g    = prod[22];
            st   = |prod[21:0];
            e1   = e0;
        end
        up = g & (st | mant[0]);
        mr = {1'b0, mant} + 25'(up);
        if (mr[24]) begin
            m  = mr[23:1];
            e2 = e1 + 11'sd1;
        end else begin
            m  = mr[22:0];
            e2 = e1;
        end
    end

    always_comb begin
        if (a_nan || b_nan) begin
            nxt = FP_QNAN;
        end else if (a_inf || b_inf) begin
            nxt = (a_zero || b_zero) ? FP_QNAN : {sgn, 8'hFF, 23'h0};
        end else if (a_zero || b_zero) begin
            nxt = {sgn, 31'h0};
        end else if (e2 >= 11'sd255) begin
            nxt = {sgn, 8'hFF, 23'h0};
        end else if (e2 <= 11'sd0) begin
            nxt = {sgn, 31'h0};
        end else begin
            nxt = {sgn, e2[7:0], m};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
        end else begin
            v_out <= v_in;
        end
        res <= nxt;
    end
endmodule

// File: rtl/qdot_top.sv
module qdot_top
    import qdot_pkg::*;
#(
    parameter int STAGES = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [STAGES*LANE_OPS_W-1:0] in_ops,
    input  logic [FP_W-1:0]              in_scale,
    output logic                         out_valid,
    output logic [FP_W-1:0]              out_result
);
    ctl_state_t state, state_nxt;
    logic       accept;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        in_ready  = 1'b0;
        unique case (state)
            ST_HOLD: begin
                state_nxt = ST_FLOW;
            end
            ST_FLOW: begin
                in_ready = 1'b1;
            end
        endcase
    end

    assign accept = in_valid & in_ready;

    logic [STAGES:0]  v_chain;
    logic [ACC_W-1:0] s_chain [STAGES+1];

    assign v_chain[0] = accept;
    assign s_chain[0] = '0;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic [LANE_OPS_W-1:0] op_k;
        if (k == 0) begin : g_direct
            assign op_k = in_ops[LANE_OPS_W-1:0];
        end else begin : g_skew
            qdot_delay #(.W(LANE_OPS_W), .D(k)) u_skew (
                .clk  (clk),
                .din  (in_ops[k*LANE_OPS_W +: LANE_OPS_W]),
                .dout (op_k)
            );
        end
        qdot_stage u_stage (
            .clk     (clk),
            .rst     (rst),
            .v_in    (v_chain[k]),
            .sum_in  (s_chain[k]),
            .ops     (op_k),
            .v_out   (v_chain[k+1]),
            .sum_out (s_chain[k+1])
        );
    end

    logic [FP_W-1:0] scale_d;
    qdot_delay #(.W(FP_W), .D(STAGES)) u_scale_dly (
        .clk  (clk),
        .din  (in_scale),
        .dout (scale_d)
    );

    logic  cv_v;
    fp32_t cv_f, cv_s;
    qdot_i2f u_i2f (
        .clk       (clk),
        .rst       (rst),
        .v_in      (v_chain[STAGES]),
        .sum_in    (s_chain[STAGES]),
        .scale_in  (scale_d),
        .v_out     (cv_v),
        .fval      (cv_f),
        .scale_out (cv_s)
    );

    qdot_fmul u_fmul (
        .clk   (clk),
        .rst   (rst),
        .v_in  (cv_v),
        .a     (cv_f),
        .b     (cv_s),
        .v_out (out_valid),
        .res   (out_result)
    );
endmodule

// File: rtl/qdot_checker.sv
module qdot_checker #(
    parameter int STAGES = 12
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_scale,
    input logic        out_valid,
    input logic [31:0] out_result
);
    localparam int LAT = STAGES + 1;

    logic [LAT:0] acc_h, nan_h, dnz_h;
    logic         acc, s_nan, s_dnz;

    assign acc   = in_valid & in_ready;
    assign s_nan = (in_scale[30:23] == 8'hFF) && (in_scale[22:0] != 23'h0);
    assign s_dnz = (in_scale[30:23] == 8'h00) && (in_scale[22:0] != 23'h0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_h <= '0;
            nan_h <= '0;
            dnz_h <= '0;
        end else begin
            acc_h <= {acc_h[LAT-1:0], acc};
            nan_h <= {nan_h[LAT-1:0], acc & s_nan};
            dnz_h <= {dnz_h[LAT-1:0], acc & s_dnz};
        end
    end

    AST_READY_UP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> in_ready);                                        // R1
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);                                       // R1
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == acc_h[LAT]);                                         // R3
    AST_NAN_SCALE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && nan_h[LAT]) |-> (out_result == 32'h7FC00000));      // R8
    AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_result[30:23] == 8'h00 && out_result[22:0] != 23'h0)); // R6
    AST_SUBNORMAL_SCALE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && dnz_h[LAT]) |-> (out_result[30:0] == 31'h0));       // R10
endmodule

bind qdot_top qdot_checker #(.STAGES(STAGES)) u_chk (.*);

// File: tb/tb_qdot_top.sv
module tb_qdot_top;
    localparam int STAGES = 12;
    localparam int OPS_W  = STAGES * 32;
    localparam int LAT    = STAGES + 1;
    localparam int QD     = 4096;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [OPS_W-1:0] in_ops = '0;
    logic [31:0]      in_scale = '0;
    logic             in_ready, out_valid;
    logic [31:0]      out_result;

    qdot_top #(.STAGES(STAGES)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_ops(in_ops), .in_scale(in_scale),
        .out_valid(out_valid), .out_result(out_result)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_q [QD];
    int          acc_q [QD];
    string       tag_q [QD];
    int wr = 0, rd = 0;

    task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic int dot(logic [OPS_W-1:0] ops);
        int s = 0;
        for (int k = 0; k < STAGES; k++) begin
            byte a0, b0, a1, b1;
            a0 = ops[k*32 +: 8];
            b0 = ops[k*32+8 +: 8];
            a1 = ops[k*32+16 +: 8];
            b1 = ops[k*32+24 +: 8];
            s += int'(a0) * int'(b0) + int'(a1) * int'(b1);
        end
        return s;
    endfunction

    function automatic logic [31:0] ref_mul(int s, logic [31:0] sc);
        logic sg; int se; logic [22:0] sf; real x; logic [63:0] db;
        int fe; logic [24:0] m; bit up;
        se = int'(sc[30:23]);
        sf = sc[22:0];
        sg = (s < 0) ^ sc[31];
        if (se == 255 && sf != 0) return 32'h7FC00000;
        if (se == 255) return (s == 0) ? 32'h7FC00000 : {sg, 8'hFF, 23'h0};
        if (se == 0 || s == 0) return {sg, 31'h0};
        x  = $itor(s < 0 ? -s : s) * $bitstoreal({1'b0, 11'(se + 896), sf, 29'h0});
        db = $realtobits(x);
        fe = int'(db[62:52]) - 896;
        m  = {2'b01, db[51:29]};
        up = db[28] && ((|db[27:0]) || m[0]);
        m  = m + 25'(up);
        if (m[24]) begin
            fe++;
            m = m >> 1;
        end
        if (fe >= 255) return {sg, 8'hFF, 23'h0};
        if (fe <= 0) return {sg, 31'h0};
        return {sg, 8'(fe), m[22:0]};
    endfunction

    function automatic logic [OPS_W-1:0] one_stage(int k, byte a0, byte b0, byte a1, byte b1);
        logic [OPS_W-1:0] v = '0;
        v[k*32 +: 32] = {b1, a1, b0, a0};
        return v;
    endfunction

    function automatic logic [OPS_W-1:0] rand_ops();
        logic [OPS_W-1:0] v;
        for (int k = 0; k < STAGES; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic push(logic [OPS_W-1:0] ops, logic [31:0] sc, logic [31:0] expv, string tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_ops   = ops;
        in_scale = sc;
        in_valid = 1'b1;
        exp_q[wr % QD] = expv;
        acc_q[wr % QD] = cyc + 1;
        tag_q[wr % QD] = tag;
        wr++;
    endtask

    task automatic send(logic [OPS_W-1:0] ops, logic [31:0] sc, string tag);
        push(ops, sc, ref_mul(dot(ops), sc), tag);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_ops   = rand_ops();
            in_scale = $urandom;
        end
    endtask

    // output monitor: data, order and latency
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd >= wr) begin
                check(1'b0, "R11 strobe with no accepted group", out_result, 32'h0);
            end else begin
                check(out_result == exp_q[rd % QD], tag_q[rd % QD], out_result, exp_q[rd % QD]);
                check(cyc - acc_q[rd % QD] == LAT, "R3 latency",
                      32'(cyc - acc_q[rd % QD]), 32'(LAT));
                rd++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(rd), 32'(wr));
        summary();
    end

    initial begin
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R1 ready in reset", 32'(in_ready), 32'h0);
            check(out_valid == 1'b0, "R1 strobe in reset", 32'(out_valid), 32'h0);
        end
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 32'h1);

        // R2 sweep: every byte against extreme multipliers, all stages and lanes
        for (int ai = -128; ai < 128; ai++) begin
            for (int bi = 0; bi < 4; bi++) begin
                byte bv, av;
                int k;
                bv = (bi == 0) ? -8'sd128 : (bi == 1) ? -8'sd1 : (bi == 2) ? 8'sd1 : 8'sd127;
                av = byte'(ai);
                k  = (ai + 128 + bi) % STAGES;
                if (bi % 2 == 0) send(one_stage(k, av, bv, 8'sd0, 8'sd0), 32'h3F800000, "R2 lane0 product");
                else             send(one_stage(k, 8'sd0, 8'sd0, av, bv), 32'h3F800000, "R2 lane1 product");
                if ((ai + 128 + bi) % 37 == 0) idle(2); // R11 bubbles with junk data
            end
        end

        // R4 exact conversion and signed zeros
        begin
            logic [OPS_W-1:0] full = '0;
            for (int k = 0; k < STAGES; k++) full[k*32 +: 32] = 32'h80808080;
            push(full, 32'h3F800000, 32'h48C00000, "R4 full-scale sum");
        end
        push(one_stage(3, 8'sd20, 8'sd5, -8'sd10, 8'sd10), 32'h3FC00000, 32'h00000000, "R4 zero sum positive scale");
        push(one_stage(7, 8'sd20, 8'sd5, -8'sd10, 8'sd10), 32'hC0000000, 32'h80000000, "R4 zero sum negative scale");

        // R5 rounding ties
        push(one_stage(0, 8'sd3, 8'sd1, 8'sd0, 8'sd0), 32'h3F800001, 32'h40400002, "R5 tie rounds up to even");
        push(one_stage(5, 8'sd5, 8'sd1, 8'sd0, 8'sd0), 32'h3F800002, 32'h40A00002, "R5 tie rounds down to even");

        // R6 smallest normal
        push(one_stage(1, 8'sd1, 8'sd1, 8'sd0, 8'sd0), 32'h00800000, 32'h00800000, "R6 min normal positive");
        push(one_stage(1, -8'sd1, 8'sd1, 8'sd0, 8'sd0), 32'h00800000, 32'h80800000, "R6 min normal negative");

        // R7 overflow
        push(one_stage(2, 8'sd2, 8'sd1, 8'sd0, 8'sd0), 32'h7F7FFFFF, 32'h7F800000, "R7 overflow positive");
        push(one_stage(2, -8'sd3, 8'sd1, 8'sd0, 8'sd0), 32'h7F7FFFFF, 32'hFF800000, "R7 overflow negative");
        push(one_stage(2, 8'sd1, 8'sd1, 8'sd0, 8'sd0), 32'h7F7FFFFF, 32'h7F7FFFFF, "R7 max finite kept");

        // R8 NaN scale
        push(one_stage(4, 8'sd9, 8'sd9, 8'sd0, 8'sd0), 32'h7FC00001, 32'h7FC00000, "R8 quiet NaN scale");
        push(one_stage(4, 8'sd9, 8'sd9, 8'sd0, 8'sd0), 32'hFF800001, 32'h7FC00000, "R8 signalling NaN scale");

        // R9 infinite scale
        push('0, 32'h7F800000, 32'h7FC00000, "R9 infinity times zero");
        push(one_stage(6, -8'sd5, 8'sd1, 8'sd0, 8'sd0), 32'hFF800000, 32'h7F800000, "R9 signed infinity");

        // R10 subnormal scale
        push(one_stage(8, 8'sd100, 8'sd1, 8'sd0, 8'sd0), 32'h00000001, 32'h00000000, "R10 subnormal scale positive");
        push(one_stage(8, -8'sd100, 8'sd1, 8'sd0, 8'sd0), 32'h00000001, 32'h80000000, "R10 subnormal scale negative");
        push(one_stage(9, 8'sd7, 8'sd1, 8'sd0, 8'sd0), 32'h007FFFFF, 32'h00000000, "R10 largest subnormal scale");

        // R12 back-to-back random groups and scales
        for (int i = 0; i < 400; i++) begin
            logic [31:0] sc;
            sc = {1'($urandom), 8'(100 + $urandom % 50), 23'($urandom)};
            send(rand_ops(), sc, "R12 streamed group");
        end
        for (int i = 0; i < 100; i++) begin
            send(rand_ops(), {1'b0, 8'(120 + $urandom % 10), 23'($urandom)}, "R5 random rounding");
            if (i % 10 == 0) idle(1 + i % 3); // R11
        end

        idle(LAT + 5);
        check(rd == wr, "R12 every group delivered", 32'(rd), 32'(wr));
        summary();
    end
endmodule